// File: doc/BRIEF.md
# Prioritized Pipeline Stage Register

This block is the state element that sits between two adjacent stages of a five-stage in-order processor. It carries one instruction's fields forward: a 3-bit stage status, a 4-bit instruction code, a 4-bit function code and a parameter-wide data word. In normal flow the stage input is captured at every clock edge, so an instruction moves forward exactly one stage per cycle.

Separate hazard control logic drives three control inputs: initialize, stall and bubble. On each edge the register takes its next contents from one of four sources. Initialize loads a supplied initial value, which may be arbitrary. Stall keeps the current contents. Bubble loads a fixed empty value. When none of the three is asserted, the stage input is loaded. The empty value is a no-op that carries its own bubble status code, so downstream logic can tell an injected bubble apart from a real instruction. The empty value and the data width are parameters.

Top module: `pipe_stage_reg`

## Requirements
- R1: While synchronous active-high `rst` is sampled high at an edge, the register loads the empty value: status 5, instruction code 1 (nop), function code 0 and data 0, whatever the control inputs are.
- R2: With `init_en`, `stall_en` and `bubble_en` all low, the next contents equal the stage input fields sampled at that edge.
- R3: With `stall_en` high and `init_en` low, the contents do not change, for as many cycles as the stall lasts.
- R4: With `bubble_en` high and both `init_en` and `stall_en` low, the register loads the empty value (status 5, instruction code 1, function code 0, data 0).
- R5: With `init_en` high, the register loads the initial-value fields.
- R6: `init_en` takes priority over both `stall_en` and `bubble_en`.
- R7: `stall_en` takes priority over `bubble_en`.
- R8: The status codes normal=1, halt=2, bad address=3, bad instruction=4 and bubble=5 all pass through a load unchanged.
- R9: A stream of distinct inputs on consecutive cycles appears at the output one cycle later, each for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_en | input | 1 | Load the initial value (highest priority) |
| stall_en | input | 1 | Keep the current contents |
| bubble_en | input | 1 | Load the empty (nop, bubble status) value |
| d_stat | input | 3 | Stage input status |
| d_icode | input | 4 | Stage input instruction code |
| d_ifun | input | 4 | Stage input function code |
| d_val | input | DATA_W | Stage input data word |
| i_stat | input | 3 | Initial value status |
| i_icode | input | 4 | Initial value instruction code |
| i_ifun | input | 4 | Initial value function code |
| i_val | input | DATA_W | Initial value data word |
| q_stat | output | 3 | Registered status |
| q_icode | output | 4 | Registered instruction code |
| q_ifun | output | 4 | Registered function code |
| q_val | output | DATA_W | Registered data word |

## Verification
The assertions check on every cycle that each control combination produces the contents its priority rank demands: the initial value whenever initialize was set, unchanged contents under a stall without initialize, the empty bubble word for a lone bubble, the stage input otherwise, and the empty word after reset. The bench alone shows that every one of the eight control combinations selects the right source against distinct, recognizable values, that all five status codes survive a load, that a stall held for several cycles keeps its word, and that a stream of back-to-back inputs emerges in order with one cycle of delay.

// File: rtl/pipe_stage_pkg.sv
package pipe_stage_pkg;

    // Stage status codes
    typedef enum logic [2:0] {
        ST_OK  = 3'd1,
        ST_HLT = 3'd2,
        ST_ADR = 3'd3,
        ST_INS = 3'd4,
        ST_BUB = 3'd5
    } stat_e;

    localparam logic [3:0] ICODE_NOP = 4'h1;

    // Next-state source selected by the priority logic
    typedef enum logic [1:0] {
        SRC_LOAD  = 2'd0,
        SRC_HOLD  = 2'd1,
        SRC_EMPTY = 2'd2,
        SRC_INIT  = 2'd3
    } src_e;

    // Fixed-width instruction fields of a stage
    typedef struct packed {
        logic [2:0] stat;
        logic [3:0] icode;
        logic [3:0] ifun;
    } fields_t;

endpackage

// File: rtl/stage_src_prio.sv
module stage_src_prio
    import pipe_stage_pkg::*;
(
    input  logic init_en,
    input  logic stall_en,
    input  logic bubble_en,
    output src_e src
);
    // Fixed ranking: initialize, stall, bubble, load
    always_comb begin
        if (init_en)        src = SRC_INIT;
        else if (stall_en)  src = SRC_HOLD;
        else if (bubble_en) src = SRC_EMPTY;
        else                src = SRC_LOAD;
    end
endmodule

// File: rtl/stage_word_mux.sv
module stage_word_mux
    import pipe_stage_pkg::*;
#(
    parameter int W = 8
) (
    input  src_e         src,
    input  logic [W-1:0] load_w,
    input  logic [W-1:0] hold_w,
    input  logic [W-1:0] empty_w,
    input  logic [W-1:0] init_w,
    output logic [W-1:0] out_w
);
    always_comb begin
        unique case (src)
            SRC_INIT:  out_w = init_w;
            SRC_HOLD:  out_w = hold_w;
            SRC_EMPTY: out_w = empty_w;
            default:   out_w = load_w;
        endcase
    end
endmodule

// File: rtl/pipe_stage_reg.sv
module pipe_stage_reg
    import pipe_stage_pkg::*;
#(
    parameter int                DATA_W      = 64,
    parameter logic [3:0]        EMPTY_ICODE = ICODE_NOP,
    parameter logic [3:0]        EMPTY_IFUN  = 4'h0,
    parameter logic [DATA_W-1:0] EMPTY_VAL   = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              init_en,
    input  logic              stall_en,
    input  logic              bubble_en,
    input  logic [2:0]        d_stat,
    input  logic [3:0]        d_icode,
    input  logic [3:0]        d_ifun,
    input  logic [DATA_W-1:0] d_val,
    input  logic [2:0]        i_stat,
    input  logic [3:0]        i_icode,
    input  logic [3:0]        i_ifun,
    input  logic [DATA_W-1:0] i_val,
    output logic [2:0]        q_stat,
    output logic [3:0]        q_icode,
    output logic [3:0]        q_ifun,
    output logic [DATA_W-1:0] q_val
);
    localparam int FLD_W  = $bits(fields_t);
    localparam int WORD_W = FLD_W + DATA_W;

    localparam fields_t EMPTY_FLD = '{stat: ST_BUB, icode: EMPTY_ICODE, ifun: EMPTY_IFUN};
    localparam logic [WORD_W-1:0] EMPTY_WORD = {EMPTY_FLD, EMPTY_VAL};

    typedef struct packed {
        fields_t           fld;
        logic [DATA_W-1:0] val;
    } stage_t;

    stage_t      st_d, st_q;
    src_e        src;
    logic [WORD_W-1:0] mux_w;

    stage_src_prio u_prio (
        .init_en   (init_en),
        .stall_en  (stall_en),
        .bubble_en (bubble_en),
        .src       (src)
    );

    stage_word_mux #(.W(WORD_W)) u_mux (
        .src     (src),
        .load_w  ({d_stat, d_icode, d_ifun, d_val}),
        .hold_w  (st_q),
        .empty_w (EMPTY_WORD),
        .init_w  ({i_stat, i_icode, i_ifun, i_val}),
        .out_w   (mux_w)
    );

    always_comb begin
        st_d = mux_w;
        if (rst) st_d = EMPTY_WORD;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign q_stat  = st_q.fld.stat;
    assign q_icode = st_q.fld.icode;
    assign q_ifun  = st_q.fld.ifun;
    assign q_val   = st_q.val;
endmodule

// File: rtl/pipe_stage_reg_chk.sv
module pipe_stage_reg_chk #(
    parameter int                DATA_W      = 64,
    parameter logic [3:0]        EMPTY_ICODE = 4'h1,
    parameter logic [3:0]        EMPTY_IFUN  = 4'h0,
    parameter logic [DATA_W-1:0] EMPTY_VAL   = '0
) (
    input logic              clk,
    input logic              rst,
    input logic              init_en,
    input logic              stall_en,
    input logic              bubble_en,
    input logic [2:0]        d_stat,
    input logic [3:0]        d_icode,
    input logic [3:0]        d_ifun,
    input logic [DATA_W-1:0] d_val,
    input logic [2:0]        i_stat,
    input logic [3:0]        i_icode,
    input logic [3:0]        i_ifun,
    input logic [DATA_W-1:0] i_val,
    input logic [2:0]        q_stat,
    input logic [3:0]        q_icode,
    input logic [3:0]        q_ifun,
    input logic [DATA_W-1:0] q_val
);
    // Reset yields the bubble word
    p_reset_empty_r1: assert property (@(posedge clk)
        rst |=> (q_stat == 3'd5 && q_icode == EMPTY_ICODE && q_ifun == EMPTY_IFUN && q_val == EMPTY_VAL));

    p_load_r2: assert property (@(posedge clk) disable iff (rst)
        (!init_en && !stall_en && !bubble_en) |=>
        (q_stat == $past(d_stat) && q_icode == $past(d_icode) &&
         q_ifun == $past(d_ifun) && q_val == $past(d_val)));

    // Stall wins over bubble as well (R7)
    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!init_en && stall_en) |=>
        ($stable(q_stat) && $stable(q_icode) && $stable(q_ifun) && $stable(q_val)));

    p_bubble_r4: assert property (@(posedge clk) disable iff (rst)
        (!init_en && !stall_en && bubble_en) |=>
        (q_stat == 3'd5 && q_icode == EMPTY_ICODE && q_ifun == EMPTY_IFUN && q_val == EMPTY_VAL));

    // Initialize wins over everything else (R6)
    p_init_r5: assert property (@(posedge clk) disable iff (rst)
        init_en |=>
        (q_stat == $past(i_stat) && q_icode == $past(i_icode) &&
         q_ifun == $past(i_ifun) && q_val == $past(i_val)));
endmodule

bind pipe_stage_reg pipe_stage_reg_chk #(
    .DATA_W(DATA_W), .EMPTY_ICODE(EMPTY_ICODE), .EMPTY_IFUN(EMPTY_IFUN), .EMPTY_VAL(EMPTY_VAL)
) u_chk (
    .clk(clk), .rst(rst), .init_en(init_en), .stall_en(stall_en), .bubble_en(bubble_en),
    .d_stat(d_stat), .d_icode(d_icode), .d_ifun(d_ifun), .d_val(d_val),
    .i_stat(i_stat), .i_icode(i_icode), .i_ifun(i_ifun), .i_val(i_val),
    .q_stat(q_stat), .q_icode(q_icode), .q_ifun(q_ifun), .q_val(q_val)
);

// File: tb/pipe_stage_reg_tb.sv
module pipe_stage_reg_tb;
    localparam int DW = 64;

    logic          clk = 1'b0;
    logic          rst;
    logic          init_en, stall_en, bubble_en;
    logic [2:0]    d_stat, i_stat, q_stat;
    logic [3:0]    d_icode, d_ifun, i_icode, i_ifun, q_icode, q_ifun;
    logic [DW-1:0] d_val, i_val, q_val;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    pipe_stage_reg #(.DATA_W(DW)) u_dut (
        .clk(clk), .rst(rst), .init_en(init_en), .stall_en(stall_en), .bubble_en(bubble_en),
        .d_stat(d_stat), .d_icode(d_icode), .d_ifun(d_ifun), .d_val(d_val),
        .i_stat(i_stat), .i_icode(i_icode), .i_ifun(i_ifun), .i_val(i_val),
        .q_stat(q_stat), .q_icode(q_icode), .q_ifun(q_ifun), .q_val(q_val)
    );

    // Vector: {init, stall, bubble, expected source}; 0 load, 1 hold, 2 empty, 3 init
    localparam logic [4:0] VEC [8] = '{
        {3'b000, 2'd0},   // R2 load
        {3'b001, 2'd2},   // R4 bubble
        {3'b010, 2'd1},   // R3 stall
        {3'b011, 2'd1},   // R7 stall beats bubble
        {3'b100, 2'd3},   // R5 init
        {3'b101, 2'd3},   // R6 init beats bubble
        {3'b110, 2'd3},   // R6 init beats stall
        {3'b111, 2'd3}    // R6 init beats both
    };

    task automatic chk(input string req, input logic [2:0] es, input logic [3:0] ei,
                       input logic [3:0] ef, input logic [DW-1:0] ev);
        n_chk++;
        if (q_stat !== es || q_icode !== ei || q_ifun !== ef || q_val !== ev) begin
            n_bad++;
            $display("FAIL %s: got stat=%0d icode=%h ifun=%h val=%h, want stat=%0d icode=%h ifun=%h val=%h",
                     req, q_stat, q_icode, q_ifun, q_val, es, ei, ef, ev);
        end
    endtask

    task automatic step;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_d(input logic [2:0] s, input logic [3:0] ic, input logic [3:0] f,
                         input logic [DW-1:0] v);
        d_stat = s; d_icode = ic; d_ifun = f; d_val = v;
    endtask

    initial begin
        rst = 1'b1; init_en = 1'b0; stall_en = 1'b0; bubble_en = 1'b0;
        set_d(3'd1, 4'h6, 4'h2, 64'h1111_2222_3333_4444);
        i_stat = 3'd3; i_icode = 4'hB; i_ifun = 4'h7; i_val = 64'hCAFE_F00D_0000_0001;
        @(negedge clk);
        step;
        // R1: reset leaves the empty word
        chk("R1 reset", 3'd5, 4'h1, 4'h0, '0);
        // R1: reset overrides init
        init_en = 1'b1;
        step;
        chk("R1 reset beats init", 3'd5, 4'h1, 4'h0, '0);
        init_en = 1'b0;
        rst = 1'b0;

        // Table walk: each combination from a known preload
        for (int k = 0; k < 8; k++) begin
            logic [DW-1:0] pre_v, new_v;
            pre_v = 64'hA000_0000_0000_0000 | 64'(k);
            new_v = 64'hB000_0000_0000_0000 | 64'(k);
            init_en = 1'b0; stall_en = 1'b0; bubble_en = 1'b0;
            set_d(3'd1, 4'h3, 4'h0, pre_v);
            step;
            {init_en, stall_en, bubble_en} = VEC[k][4:2];
            set_d(3'd2, 4'h5, 4'h9, new_v);
            step;
            case (VEC[k][1:0])
                2'd0: chk("R2 table load", 3'd2, 4'h5, 4'h9, new_v);
                2'd1: chk("R3/R7 table hold", 3'd1, 4'h3, 4'h0, pre_v);
                2'd2: chk("R4 table bubble", 3'd5, 4'h1, 4'h0, '0);
                default: chk("R5/R6 table init", i_stat, i_icode, i_ifun, i_val);
            endcase
        end
        init_en = 1'b0; stall_en = 1'b0; bubble_en = 1'b0;

        // R8: every status code survives a load
        for (int s = 1; s <= 5; s++) begin
            set_d(3'(s), 4'h2, 4'h1, 64'(s * 7));
            step;
            chk("R8 status pass", 3'(s), 4'h2, 4'h1, 64'(s * 7));
        end

        // R3: long stall holds the word while inputs change
        set_d(3'd1, 4'hC, 4'h4, 64'h5555_AAAA_5555_AAAA);
        step;
        stall_en = 1'b1;
        for (int c = 0; c < 4; c++) begin
            set_d(3'd4, 4'h0, 4'hF, 64'(c));
            step;
            chk("R3 multi-cycle stall", 3'd1, 4'hC, 4'h4, 64'h5555_AAAA_5555_AAAA);
        end
        stall_en = 1'b0;

        // R9: back-to-back stream with one cycle of delay
        for (int c = 0; c < 6; c++) begin
            set_d(3'd1, 4'(c + 2), 4'(c), 64'h7700 + 64'(c));
            step;
            chk("R9 stream", 3'd1, 4'(c + 2), 4'(c), 64'h7700 + 64'(c));
        end

        // R4: bubble after real data, then resume load
        bubble_en = 1'b1;
        step;
        chk("R4 bubble inject", 3'd5, 4'h1, 4'h0, '0);
        bubble_en = 1'b0;
        set_d(3'd2, 4'h0, 4'h0, 64'hDEAD);
        step;
        chk("R2 resume after bubble", 3'd2, 4'h0, 4'h0, 64'hDEAD);

        // R1: mid-run reset with stall asserted
        rst = 1'b1; stall_en = 1'b1;
        step;
        chk("R1 reset beats stall", 3'd5, 4'h1, 4'h0, '0);
        rst = 1'b0; stall_en = 1'b0;

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout, want completion");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule